// File: doc/BRIEF.md
# Strap-Resistor Bus Address Decoder

This block picks the 7-bit management-bus address of a device once, right after power-up. Each of two strap pins has a resistor to ground. For one pin at a time, the block turns on a bias current source for that pin and waits a fixed settling time. It then asks an external 12-bit ADC for one conversion over a level-request / pulse-acknowledge handshake. The block sorts each code into a resistor bin or into a short or open fault. It combines the two bins into the address, holds the address with a valid flag until the next reset, and reports two things about it: whether the address is the fallback that hands the shared pins to the debug port, and whether the address falls in the prohibited or avoided set.

The bin boundaries form a geometric series of ADC codes. Each boundary is 1.25 times the one below it, computed in integers as `E(k+1) = E(k) + floor(E(k)/4)`, so a bin's width follows the spread of 1% resistors. The capture runs as a state machine with these states:

- IDLE → BIAS0 (unconditional)
- BIAS0 → SETTLE0 (unconditional)
- SETTLE0 → SAMPLE0 (when the settle timer expires)
- SAMPLE0 → BIAS1 (on the ADC acknowledge)
- BIAS1 → SETTLE1 (unconditional)
- SETTLE1 → SAMPLE1 (when the settle timer expires)
- SAMPLE1 → COMPUTE (on the ADC acknowledge)
- COMPUTE → DONE (unconditional)
- DONE → DONE (held until reset)

Top module: `strap_addr_decoder`

## Requirements
- R1: While reset is asserted, all outputs are 0: `addr_o`, `addr_valid_o`, `debug_en_o`, `addr_reserved_o`, `bias_en_o` and `adc_req_o`.
- R2: Pin 0 is measured before pin 1. `bias_en_o[0]` is high only in BIAS0, SETTLE0 and SAMPLE0, and `bias_en_o[1]` only in BIAS1, SETTLE1 and SAMPLE1. The two bits are never high together, and `adc_req_o` is high only while one of them is high.
- R3: `adc_req_o` rises only after the active pin's bias has been on for at least SETTLE_CYCLES clock cycles.
- R4: `adc_req_o` stays high until a cycle in which `adc_ack_i` is high. Exactly one conversion is accepted per pin, so there are two per reset.
- R5: With E0 = LOW_EDGE (default 400), a code c with E(k) ≤ c < E(k+1) (k = 0..7) is given bin BIN_BASE+k (default 4..11). The bin includes its lower edge and excludes its upper edge.
- R6: The address is 12 × bin(pin 1) + bin(pin 0).
- R7: A code below E0 on either pin (short) forces the address to 126.
- R8: A code at or above E8 on either pin (open) forces the address to 126.
- R9: A computed sum above 127 is reported as 126.
- R10: `debug_en_o` is high exactly when `addr_valid_o` is high and `addr_o` is 126.
- R11: `addr_reserved_o` is high exactly when `addr_valid_o` is high and `addr_o` is 0, 11, 12 or 127.
- R12: Once `addr_valid_o` rises, it stays high and `addr_o` stays unchanged until reset. No further conversion is requested in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the capture starts when it is released |
| bias_en_o | output | 2 | Bias-current enable, one bit per strap pin |
| adc_req_o | output | 1 | Conversion request, held high until acknowledged |
| adc_ack_i | input | 1 | One-cycle acknowledge; `adc_data_i` is valid in the same cycle |
| adc_data_i | input | ADC_W | Conversion result |
| addr_o | output | ADDR_W | Decoded bus address |
| addr_valid_o | output | 1 | High once the address is final |
| debug_en_o | output | 1 | Fallback address in use; the shared pins belong to the debug port |
| addr_reserved_o | output | 1 | The address is prohibited or should be avoided |

## Verification
The bench sets codes exactly on a bin's lower edge, one code below a bin's upper edge, and codes just outside E0 and E8. A classifier with an off-by-one compare would put such a code in the neighbouring bin and return an address that differs by 1 or by 12.

Shorts and opens are injected on each pin separately. A design that checked only one pin, or that checked only one fault kind, would report a normal address instead of 126.

Two pin pairs test the top of the address range:
- bins 11 and 4 sum to 136, which must fold to 126;
- bins 10 and 7 give 127, which a weak reserved-address decode or range fold would mishandle.

The bench also records the order of the pins, the bias length before each request, and the conversion count during a hold period. This exposes a swapped sequence, a short settle, a request made with no bias on, or a re-capture after DONE.

// File: rtl/strap_addr_pkg.sv
package strap_addr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BIAS0,
        ST_SETTLE0,
        ST_SAMPLE0,
        ST_BIAS1,
        ST_SETTLE1,
        ST_SAMPLE1,
        ST_COMPUTE,
        ST_DONE
    } cap_state_e;

    // Boundary k of the geometric ladder: each step adds a quarter (ratio 1.25).
    function automatic int unsigned bin_edge(input int unsigned low_edge, input int unsigned k);
        int unsigned e;
        e = low_edge;
        for (int unsigned i = 0; i < k; i++) begin
            e = e + e / 4;
        end
        return e;
    endfunction

endpackage

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
    parameter int SETTLE_CYCLES = 16,
    parameter int CNT_W         = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CNT_W'(SETTLE_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/strap_bin_classifier.sv
module strap_bin_classifier
    import strap_addr_pkg::*;
#(
    parameter int ADC_W    = 12,
    parameter int NUM_BINS = 8,
    parameter int BIN_BASE = 4,
    parameter int LOW_EDGE = 400,
    parameter int BIN_W    = $clog2(BIN_BASE + NUM_BINS)
) (
    input  logic [ADC_W-1:0] code_i,
    output logic [BIN_W-1:0] bin_o,
    output logic             short_o,
    output logic             open_o
);

    logic [NUM_BINS:0] at_or_above;

    for (genvar k = 0; k <= NUM_BINS; k++) begin : g_edge
        localparam int unsigned EDGE = bin_edge(LOW_EDGE, k);
        assign at_or_above[k] = ({{(32-ADC_W){1'b0}}, code_i} >= 32'(EDGE));
    end

    always_comb begin
        int idx;
        idx = 0;
        for (int k = 1; k < NUM_BINS; k++) begin
            if (at_or_above[k]) idx = idx + 1;
        end
        bin_o   = BIN_W'(BIN_BASE + idx);
        short_o = !at_or_above[0];
        open_o  = at_or_above[NUM_BINS];
    end

endmodule

// File: rtl/strap_addr_combiner.sv
module strap_addr_combiner #(
    parameter int BIN_W         = 4,
    parameter int HI_WEIGHT     = 12,
    parameter int ADDR_W        = 7,
    parameter int FALLBACK_ADDR = 126
) (
    input  logic [BIN_W-1:0]  bin_lo_i,
    input  logic [BIN_W-1:0]  bin_hi_i,
    input  logic              fault_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int RAW_W    = BIN_W + $clog2(HI_WEIGHT + 1) + 1;
    localparam int SUM_W    = (RAW_W > ADDR_W) ? RAW_W : ADDR_W + 1;
    localparam int MAX_ADDR = (1 << ADDR_W) - 1;

    logic [SUM_W-1:0] sum;

    assign sum = SUM_W'(HI_WEIGHT) * SUM_W'(bin_hi_i) + SUM_W'(bin_lo_i);

    always_comb begin
        if (fault_i || (sum > SUM_W'(MAX_ADDR))) begin
            addr_o = ADDR_W'(FALLBACK_ADDR);
        end else begin
            addr_o = sum[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
    import strap_addr_pkg::*;
#(
    parameter int ADC_W         = 12,
    parameter int NUM_BINS      = 8,
    parameter int BIN_BASE      = 4,
    parameter int LOW_EDGE      = 400,
    parameter int SETTLE_CYCLES = 16,
    parameter int HI_WEIGHT     = 12,
    parameter int ADDR_W        = 7,
    parameter int FALLBACK_ADDR = 126,
    parameter int AVOID_ADDR    = 11,
    parameter int ALERT_ADDR    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [1:0]        bias_en_o,
    output logic              adc_req_o,
    input  logic              adc_ack_i,
    input  logic [ADC_W-1:0]  adc_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              debug_en_o,
    output logic              addr_reserved_o
);

    localparam int BIN_W     = $clog2(BIN_BASE + NUM_BINS);
    localparam int TEST_ADDR = (1 << ADDR_W) - 1;

    cap_state_e state_q, state_d;

    logic             settle_run;
    logic             settle_done;
    logic [BIN_W-1:0] cls_bin;
    logic             cls_short;
    logic             cls_open;
    logic [BIN_W-1:0] bin0_q, bin1_q;
    logic             fault0_q, fault1_q;
    logic [ADDR_W-1:0] addr_comb;
    logic [ADDR_W-1:0] addr_q;

    strap_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (settle_run),
        .expired_o (settle_done)
    );

    strap_bin_classifier #(
        .ADC_W    (ADC_W),
        .NUM_BINS (NUM_BINS),
        .BIN_BASE (BIN_BASE),
        .LOW_EDGE (LOW_EDGE),
        .BIN_W    (BIN_W)
    ) u_classify (
        .code_i  (adc_data_i),
        .bin_o   (cls_bin),
        .short_o (cls_short),
        .open_o  (cls_open)
    );

    strap_addr_combiner #(
        .BIN_W         (BIN_W),
        .HI_WEIGHT     (HI_WEIGHT),
        .ADDR_W        (ADDR_W),
        .FALLBACK_ADDR (FALLBACK_ADDR)
    ) u_combine (
        .bin_lo_i (bin0_q),
        .bin_hi_i (bin1_q),
        .fault_i  (fault0_q || fault1_q),
        .addr_o   (addr_comb)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_BIAS0;
            ST_BIAS0:   state_d = ST_SETTLE0;
            ST_SETTLE0: if (settle_done) state_d = ST_SAMPLE0;
            ST_SAMPLE0: if (adc_ack_i) state_d = ST_BIAS1;
            ST_BIAS1:   state_d = ST_SETTLE1;
            ST_SETTLE1: if (settle_done) state_d = ST_SAMPLE1;
            ST_SAMPLE1: if (adc_ack_i) state_d = ST_COMPUTE;
            ST_COMPUTE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sample capture and address latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin0_q   <= '0;
            bin1_q   <= '0;
            fault0_q <= 1'b0;
            fault1_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            if (state_q == ST_SAMPLE0 && adc_ack_i) begin
                bin0_q   <= cls_bin;
                fault0_q <= cls_short || cls_open;
            end
            if (state_q == ST_SAMPLE1 && adc_ack_i) begin
                bin1_q   <= cls_bin;
                fault1_q <= cls_short || cls_open;
            end
            if (state_q == ST_COMPUTE) begin
                addr_q <= addr_comb;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        bias_en_o    = 2'b00;
        adc_req_o    = 1'b0;
        settle_run   = 1'b0;
        addr_valid_o = 1'b0;
        unique case (state_q)
            ST_BIAS0:   bias_en_o = 2'b01;
            ST_SETTLE0: begin bias_en_o = 2'b01; settle_run = 1'b1; end
            ST_SAMPLE0: begin bias_en_o = 2'b01; adc_req_o = 1'b1; end
            ST_BIAS1:   bias_en_o = 2'b10;
            ST_SETTLE1: begin bias_en_o = 2'b10; settle_run = 1'b1; end
            ST_SAMPLE1: begin bias_en_o = 2'b10; adc_req_o = 1'b1; end
            ST_DONE:    addr_valid_o = 1'b1;
            default:    ;
        endcase
        addr_o          = addr_q;
        debug_en_o      = addr_valid_o && (addr_q == ADDR_W'(FALLBACK_ADDR));
        addr_reserved_o = addr_valid_o &&
                          ((addr_q == '0) ||
                           (addr_q == ADDR_W'(AVOID_ADDR)) ||
                           (addr_q == ADDR_W'(ALERT_ADDR)) ||
                           (addr_q == ADDR_W'(TEST_ADDR)));
    end

endmodule

// File: rtl/strap_addr_checker.sv
module strap_addr_checker #(
    parameter int SETTLE_CYCLES = 16,
    parameter int ADDR_W        = 7,
    parameter int FALLBACK_ADDR = 126
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bias_en_o,
    input logic              adc_req_o,
    input logic              adc_ack_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_valid_o,
    input logic              debug_en_o,
    input logic              addr_reserved_o
);

    logic [1:0]  bias_prev;
    logic [15:0] bias_run;

    // Cycles the current bias pattern has been held before the present one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bias_prev <= 2'b00;
            bias_run  <= '0;
        end else begin
            bias_prev <= bias_en_o;
            if (bias_en_o != bias_prev) begin
                bias_run <= '0;
            end else if (bias_run != 16'hFFFF) begin
                bias_run <= bias_run + 1'b1;
            end
        end
    end

    p_bias_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bias_en_o));

    p_req_needs_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_o |-> (bias_en_o != 2'b00));

    p_settle_before_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_req_o) |-> (32'(bias_run) >= SETTLE_CYCLES));

    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req_o && !adc_ack_i) |=> adc_req_o);

    p_debug_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> (debug_en_o == (addr_o == ADDR_W'(FALLBACK_ADDR))));

    p_flags_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid_o |-> (!debug_en_o && !addr_reserved_o));

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |=> (addr_valid_o && $stable(addr_o)));

    p_no_req_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> !adc_req_o);

endmodule

bind strap_addr_decoder strap_addr_checker #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .ADDR_W        (ADDR_W),
    .FALLBACK_ADDR (FALLBACK_ADDR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bias_en_o       (bias_en_o),
    .adc_req_o       (adc_req_o),
    .adc_ack_i       (adc_ack_i),
    .addr_o          (addr_o),
    .addr_valid_o    (addr_valid_o),
    .debug_en_o      (debug_en_o),
    .addr_reserved_o (addr_reserved_o)
);

// File: tb/strap_addr_decoder_tb.sv
module strap_addr_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;
    localparam int LOW_EDGE   = 400;
    localparam int ADC_LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bias_en;
    logic        adc_req;
    logic        adc_ack = 1'b0;
    logic [11:0] adc_data = '0;
    logic [6:0]  addr;
    logic        addr_valid;
    logic        debug_en;
    logic        addr_reserved;

    int checks = 0;
    int failures = 0;
    int edge_tab [9];

    int code_pin0 = 0;
    int code_pin1 = 0;
    int conv_cnt = 0;
    int first_pin = -1;
    int bias_bad = 0;
    int min_run = 1000000;
    int run_len = 0;
    int wait_cnt = 0;
    logic [1:0] prev_bias = 2'b00;
    logic prev_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_addr_decoder #(.SETTLE_CYCLES(SETTLE), .LOW_EDGE(LOW_EDGE)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bias_en_o       (bias_en),
        .adc_req_o       (adc_req),
        .adc_ack_i       (adc_ack),
        .adc_data_i      (adc_data),
        .addr_o          (addr),
        .addr_valid_o    (addr_valid),
        .debug_en_o      (debug_en),
        .addr_reserved_o (addr_reserved)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mid(input int k);
        return (edge_tab[k] + edge_tab[k+1]) / 2;
    endfunction

    // ADC model and sequence monitor, evaluated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            adc_ack = 1'b0;
            if (!rst_n) begin
                wait_cnt = 0;
                run_len = 0;
                prev_bias = 2'b00;
                prev_req = 1'b0;
            end else begin
                if (bias_en != prev_bias) run_len = 1;
                else run_len++;
                if (adc_req && !prev_req && run_len < min_run) min_run = run_len;
                if (adc_req) begin
                    if (bias_en == 2'b00) bias_bad++;
                    if (wait_cnt == ADC_LAT) begin
                        adc_ack = 1'b1;
                        adc_data = bias_en[1] ? 12'(code_pin1) : 12'(code_pin0);
                        if (conv_cnt == 0) first_pin = bias_en[1] ? 1 : 0;
                        conv_cnt++;
                        wait_cnt = 0;
                    end else begin
                        wait_cnt++;
                    end
                end else begin
                    wait_cnt = 0;
                end
                prev_bias = bias_en;
                prev_req = adc_req;
            end
        end
    end

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        conv_cnt = 0;
        first_pin = -1;
        bias_bad = 0;
        min_run = 1000000;
    endtask

    // R1: reset state seen at the ports
    task automatic test_reset();
        apply_reset();
        chk(addr == 7'd0, "R1 addr", int'(addr), 0);
        chk(!addr_valid && !debug_en && !addr_reserved, "R1 flags",
            int'({addr_valid, debug_en, addr_reserved}), 0);
        chk(bias_en == 2'b00 && !adc_req, "R1 bias/req", int'({bias_en, adc_req}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_case(input int c0, input int c1, input int exp_addr,
                            input bit exp_dbg, input bit exp_rsv, input string tag);
        int guard;
        logic [6:0] held;
        apply_reset();
        code_pin0 = c0;
        code_pin1 = c1;
        rst_n = 1'b1;
        guard = 0;
        while (!addr_valid && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(addr_valid, {tag, " valid reached"}, int'(addr_valid), 1);
        chk(addr == 7'(exp_addr), {tag, " address"}, int'(addr), exp_addr);
        chk(debug_en == exp_dbg, {"R10 ", tag, " debug_en"}, int'(debug_en), int'(exp_dbg));
        chk(addr_reserved == exp_rsv, {"R11 ", tag, " reserved"}, int'(addr_reserved), int'(exp_rsv));
        chk(first_pin == 0, {"R2 ", tag, " pin order"}, first_pin, 0);
        chk(bias_bad == 0, {"R2 ", tag, " request without bias"}, bias_bad, 0);
        chk(min_run >= SETTLE + 1, {"R3 ", tag, " settle length"}, min_run, SETTLE + 1);
        chk(conv_cnt == 2, {"R4 ", tag, " conversions"}, conv_cnt, 2);
        held = addr;
        code_pin0 = 0;
        code_pin1 = 4095;
        repeat (40) @(negedge clk);
        chk(addr_valid && addr == held, {"R12 ", tag, " hold"}, int'(addr), int'(held));
        chk(conv_cnt == 2, {"R12 ", tag, " no recapture"}, conv_cnt, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        edge_tab[0] = LOW_EDGE;
        for (int k = 1; k < 9; k++) edge_tab[k] = edge_tab[k-1] + edge_tab[k-1] / 4;

        test_reset();
        // R5 R6: mid-bin codes, bins 4 and 4 -> 52
        run_case(mid(0), mid(0), 52, 0, 0, "R5 R6 low bins");
        // R6: lo bin 11, hi bin 9 -> 119
        run_case(mid(7), mid(5), 119, 0, 0, "R6 mixed bins");
        // R5: lower edge inclusive (bin 6), upper edge exclusive (bin 4) -> 54
        run_case(edge_tab[2], edge_tab[1] - 1, 54, 0, 0, "R5 edges a");
        // R5: E8-1 is bin 11, E3 is bin 7 -> 95
        run_case(edge_tab[8] - 1, edge_tab[3], 95, 0, 0, "R5 edges b");
        // R7: shorts
        run_case(edge_tab[0] - 1, mid(2), 126, 1, 0, "R7 short pin0");
        run_case(mid(2), 0, 126, 1, 0, "R7 short pin1");
        // R8: opens
        run_case(4095, mid(1), 126, 1, 0, "R8 open pin0");
        run_case(mid(1), edge_tab[8], 126, 1, 0, "R8 open pin1");
        // R9: 12*11+4 = 136 folds to 126
        run_case(mid(0), mid(7), 126, 1, 0, "R9 overflow");
        // R10: natural 126 = 12*10+6
        run_case(mid(2), mid(6), 126, 1, 0, "R10 natural fallback");
        // R11: 12*10+7 = 127 reserved
        run_case(mid(3), mid(6), 127, 0, 1, "R11 test address");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule